// File: doc/BRIEF.md
# Bit-Slice Shift and Destination Control

This block sits beside the ALU of a narrow processor slice. A 3-bit destination code is presented on every cycle. From that one code the block settles three things. It decides whether the ALU result is written back to the register file, and whether it goes back unchanged, halved (shifted toward the LSB) or doubled (shifted toward the MSB). It decides whether the Q register loads the ALU result, shifts in either direction or keeps its value. It also chooses whether the Y output shows the ALU result or the A-port operand.

Several slices are chained through serial shift pins at the two ends of the register-file path and at the two ends of the Q path. Each of these pins is bidirectional on a real board. Here each pin is split into an input, an output and an output-enable. When a shift is selected, the end that receives the bit listens to its neighbour, and the end that loses a bit drives it out. The Q register is held inside the block and updates on the rising clock edge. The register-file write data and its write strobe appear on a write bus for the external storage.

Top module: `bsd_dest_ctl`

## Requirements
- R1: While `rst_n` is low, the Q register is cleared to zero on the rising clock edge, and `q_o` reads 0 after that edge.
- R2: `y_o` equals `a_i` when the code is 2, and equals `f_i` for every other code.
- R3: `ram_we_o` is 1 for codes 2 to 7 and 0 for codes 0 and 1. For codes 0 to 3, `ram_wdata_o` equals `f_i`.
- R4: For codes 4 and 5 (shift down), the write data is `{ram_msb_in, f_i[W-1:1]}`. `ram_lsb_oe` is 1 with `ram_lsb_out` = `f_i[0]`, and `ram_msb_oe` is 0.
- R5: For codes 6 and 7 (shift up), the write data is `{f_i[W-2:0], ram_lsb_in}`. `ram_msb_oe` is 1 with `ram_msb_out` = `f_i[W-1]`, and `ram_lsb_oe` is 0.
- R6: At the rising clock edge, code 0 loads `f_i` into Q.
- R7: For codes 0 to 3, all four output-enables are 0 and all four pin outputs are 0. The four pin inputs then have no effect on `ram_wdata_o` or on the next Q.
- R8: For codes 1, 2, 3, 5 and 7, Q keeps its value. For codes 5 and 7, both Q pin enables are 0.
- R9: Code 4 loads `{q_msb_in, q[W-1:1]}` into Q at the rising clock edge. During code 4, `q_lsb_oe` is 1 with `q_lsb_out` = `q_o[0]`, and `q_msb_oe` is 0.
- R10: Code 6 loads `{q[W-2:0], q_lsb_in}` into Q at the rising clock edge. During code 6, `q_msb_oe` is 1 with `q_msb_out` = `q_o[W-1]`, and `q_lsb_oe` is 0. In both code 4 and code 6, the register-file write happens in the same cycle as the Q shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; Q updates on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset of Q |
| dest_i | input | 3 | Destination code |
| f_i | input | W | ALU result |
| a_i | input | W | A-port operand |
| ram_lsb_in | input | 1 | Register-path LSB pin, input side |
| ram_msb_in | input | 1 | Register-path MSB pin, input side |
| q_lsb_in | input | 1 | Q-path LSB pin, input side |
| q_msb_in | input | 1 | Q-path MSB pin, input side |
| ram_lsb_out | output | 1 | Register-path LSB pin, driven value |
| ram_lsb_oe | output | 1 | Register-path LSB pin, output enable |
| ram_msb_out | output | 1 | Register-path MSB pin, driven value |
| ram_msb_oe | output | 1 | Register-path MSB pin, output enable |
| q_lsb_out | output | 1 | Q-path LSB pin, driven value |
| q_lsb_oe | output | 1 | Q-path LSB pin, output enable |
| q_msb_out | output | 1 | Q-path MSB pin, driven value |
| q_msb_oe | output | 1 | Q-path MSB pin, output enable |
| y_o | output | W | Y output, F or A |
| ram_wdata_o | output | W | Register-file write data |
| ram_we_o | output | 1 | Register-file write enable |
| q_o | output | W | Current Q register value |

## Verification
The bench sets the serial pin inputs to values that differ from the bits the design would otherwise shift in. A design that reversed the fill ends, or that read a pin while in a non-shift code, therefore writes a visibly wrong word or Q value. Codes 5 and 7 are run back to back with codes 4 and 6. This catches a design that shifts Q on every shift code, or that leaves a Q pin driven when only the register path is shifting. Code 2 is run with A and F set to different values, which exposes a Y source select decoded from the wrong code. A reset in the middle of the run checks that Q clears even when the code on that cycle would load it.

// File: rtl/bsd_pkg.sv
package bsd_pkg;

  typedef enum logic [1:0] {
    RM_NONE  = 2'd0,
    RM_WRITE = 2'd1,
    RM_DOWN  = 2'd2,
    RM_UP    = 2'd3
  } ram_mode_e;

  typedef enum logic [1:0] {
    QM_HOLD = 2'd0,
    QM_LOAD = 2'd1,
    QM_DOWN = 2'd2,
    QM_UP   = 2'd3
  } q_mode_e;

  typedef struct packed {
    ram_mode_e ram_mode;
    q_mode_e   q_mode;
    logic      y_from_a;
  } dest_ctl_t;

  // Destination code to control bundle; the code values are architectural.
  function automatic dest_ctl_t decode_dest(input logic [2:0] code);
    dest_ctl_t c;
    c.ram_mode = RM_NONE;
    c.q_mode   = QM_HOLD;
    c.y_from_a = 1'b0;
    case (code)
      3'd0: c.q_mode = QM_LOAD;
      3'd1: c.q_mode = QM_HOLD;
      3'd2: begin
        c.ram_mode = RM_WRITE;
        c.y_from_a = 1'b1;
      end
      3'd3: c.ram_mode = RM_WRITE;
      3'd4: begin
        c.ram_mode = RM_DOWN;
        c.q_mode   = QM_DOWN;
      end
      3'd5: c.ram_mode = RM_DOWN;
      3'd6: begin
        c.ram_mode = RM_UP;
        c.q_mode   = QM_UP;
      end
      default: c.ram_mode = RM_UP;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/bsd_decode.sv
module bsd_decode
  import bsd_pkg::*;
(
  input  logic [2:0] code_i,
  output dest_ctl_t  ctl_o
);

  always_comb begin
    ctl_o = decode_dest(code_i);
  end

endmodule

// File: rtl/bsd_ram_shift.sv
module bsd_ram_shift
  import bsd_pkg::*;
#(
  parameter int W = 4
) (
  input  ram_mode_e      mode_i,
  input  logic [W-1:0]   f_i,
  input  logic           lsb_in,
  input  logic           msb_in,
  output logic [W-1:0]   wdata_o,
  output logic           we_o,
  output logic           lsb_out,
  output logic           lsb_oe,
  output logic           msb_out,
  output logic           msb_oe
);

  localparam int MSB = W - 1;

  function automatic logic [W-1:0] halve(input logic [W-1:0] v, input logic fill);
    return {fill, v[MSB:1]};
  endfunction

  function automatic logic [W-1:0] twice(input logic [W-1:0] v, input logic fill);
    return {v[MSB-1:0], fill};
  endfunction

  logic going_down;
  logic going_up;

  assign going_down = (mode_i == RM_DOWN);
  assign going_up   = (mode_i == RM_UP);

  always_comb begin
    we_o = (mode_i != RM_NONE);
    if (going_down)    wdata_o = halve(f_i, msb_in);
    else if (going_up) wdata_o = twice(f_i, lsb_in);
    else               wdata_o = f_i;
  end

  assign lsb_oe  = going_down;
  assign lsb_out = going_down & f_i[0];
  assign msb_oe  = going_up;
  assign msb_out = going_up & f_i[MSB];

endmodule

// File: rtl/bsd_q_shift.sv
module bsd_q_shift
  import bsd_pkg::*;
#(
  parameter int W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  q_mode_e        mode_i,
  input  logic [W-1:0]   f_i,
  input  logic           lsb_in,
  input  logic           msb_in,
  output logic [W-1:0]   q_o,
  output logic           lsb_out,
  output logic           lsb_oe,
  output logic           msb_out,
  output logic           msb_oe
);

  localparam int MSB = W - 1;

  logic [W-1:0] q_r;
  logic [W-1:0] q_next;

  always_comb begin
    case (mode_i)
      QM_LOAD: q_next = f_i;
      QM_DOWN: q_next = {msb_in, q_r[MSB:1]};
      QM_UP:   q_next = {q_r[MSB-1:0], lsb_in};
      default: q_next = q_r;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_next;
  end

  assign q_o     = q_r;
  assign lsb_oe  = (mode_i == QM_DOWN);
  assign lsb_out = lsb_oe & q_r[0];
  assign msb_oe  = (mode_i == QM_UP);
  assign msb_out = msb_oe & q_r[MSB];

endmodule

// File: rtl/bsd_y_mux.sv
module bsd_y_mux #(
  parameter int W = 4
) (
  input  logic         from_a_i,
  input  logic [W-1:0] f_i,
  input  logic [W-1:0] a_i,
  output logic [W-1:0] y_o
);

  assign y_o = from_a_i ? a_i : f_i;

endmodule

// File: rtl/bsd_dest_ctl.sv
module bsd_dest_ctl
  import bsd_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   dest_i,
  input  logic [W-1:0] f_i,
  input  logic [W-1:0] a_i,
  input  logic         ram_lsb_in,
  input  logic         ram_msb_in,
  input  logic         q_lsb_in,
  input  logic         q_msb_in,
  output logic         ram_lsb_out,
  output logic         ram_lsb_oe,
  output logic         ram_msb_out,
  output logic         ram_msb_oe,
  output logic         q_lsb_out,
  output logic         q_lsb_oe,
  output logic         q_msb_out,
  output logic         q_msb_oe,
  output logic [W-1:0] y_o,
  output logic [W-1:0] ram_wdata_o,
  output logic         ram_we_o,
  output logic [W-1:0] q_o
);

  dest_ctl_t ctl;

  bsd_decode u_decode (
    .code_i (dest_i),
    .ctl_o  (ctl)
  );

  bsd_ram_shift #(.W(W)) u_ram_shift (
    .mode_i  (ctl.ram_mode),
    .f_i     (f_i),
    .lsb_in  (ram_lsb_in),
    .msb_in  (ram_msb_in),
    .wdata_o (ram_wdata_o),
    .we_o    (ram_we_o),
    .lsb_out (ram_lsb_out),
    .lsb_oe  (ram_lsb_oe),
    .msb_out (ram_msb_out),
    .msb_oe  (ram_msb_oe)
  );

  bsd_q_shift #(.W(W)) u_q_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_i  (ctl.q_mode),
    .f_i     (f_i),
    .lsb_in  (q_lsb_in),
    .msb_in  (q_msb_in),
    .q_o     (q_o),
    .lsb_out (q_lsb_out),
    .lsb_oe  (q_lsb_oe),
    .msb_out (q_msb_out),
    .msb_oe  (q_msb_oe)
  );

  bsd_y_mux #(.W(W)) u_y_mux (
    .from_a_i (ctl.y_from_a),
    .f_i      (f_i),
    .a_i      (a_i),
    .y_o      (y_o)
  );

endmodule

// File: rtl/bsd_dest_ctl_chk.sv
module bsd_dest_ctl_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic [2:0]   dest_i,
  input logic [W-1:0] f_i,
  input logic [W-1:0] a_i,
  input logic         ram_lsb_in,
  input logic         ram_msb_in,
  input logic         q_lsb_in,
  input logic         q_msb_in,
  input logic         ram_lsb_out,
  input logic         ram_lsb_oe,
  input logic         ram_msb_out,
  input logic         ram_msb_oe,
  input logic         q_lsb_out,
  input logic         q_lsb_oe,
  input logic         q_msb_out,
  input logic         q_msb_oe,
  input logic [W-1:0] y_o,
  input logic [W-1:0] ram_wdata_o,
  input logic         ram_we_o,
  input logic [W-1:0] q_o
);

  // R1
  p_reset_clear_r1: assert property (@(posedge clk) !rst_n |=> (q_o == '0));

  p_y_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dest_i != 3'd2) |-> (y_o == f_i));

  p_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dest_i < 3'd2) |-> !ram_we_o);

  p_down_path_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dest_i == 3'd4 || dest_i == 3'd5) |->
      (ram_we_o && ram_lsb_oe && !ram_msb_oe && ram_lsb_out == f_i[0]
       && ram_wdata_o[W-1] == ram_msb_in));

  p_up_path_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dest_i == 3'd6 || dest_i == 3'd7) |->
      (ram_we_o && ram_msb_oe && !ram_lsb_oe && ram_msb_out == f_i[W-1]
       && ram_wdata_o[0] == ram_lsb_in));

  p_q_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dest_i == 3'd0) |=> (q_o == $past(f_i)));

  p_quiet_pins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dest_i < 3'd4) |->
      !(ram_lsb_oe || ram_msb_oe || q_lsb_oe || q_msb_oe ||
        ram_lsb_out || ram_msb_out || q_lsb_out || q_msb_out));

  p_q_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dest_i != 3'd0 && dest_i != 3'd4 && dest_i != 3'd6) |=> $stable(q_o));

  p_oe_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_lsb_oe, ram_msb_oe}) && $onehot0({q_lsb_oe, q_msb_oe}));

  p_q_down_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dest_i == 3'd4) |=> (q_o == {$past(q_msb_in), $past(q_o[W-1:1])}));

  p_q_up_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dest_i == 3'd6) |=> (q_o == {$past(q_o[W-2:0]), $past(q_lsb_in)}));

endmodule

bind bsd_dest_ctl bsd_dest_ctl_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .dest_i      (dest_i),
  .f_i         (f_i),
  .a_i         (a_i),
  .ram_lsb_in  (ram_lsb_in),
  .ram_msb_in  (ram_msb_in),
  .q_lsb_in    (q_lsb_in),
  .q_msb_in    (q_msb_in),
  .ram_lsb_out (ram_lsb_out),
  .ram_lsb_oe  (ram_lsb_oe),
  .ram_msb_out (ram_msb_out),
  .ram_msb_oe  (ram_msb_oe),
  .q_lsb_out   (q_lsb_out),
  .q_lsb_oe    (q_lsb_oe),
  .q_msb_out   (q_msb_out),
  .q_msb_oe    (q_msb_oe),
  .y_o         (y_o),
  .ram_wdata_o (ram_wdata_o),
  .ram_we_o    (ram_we_o),
  .q_o         (q_o)
);

// File: tb/bsd_dest_ctl_tb.sv
module bsd_dest_ctl_tb;

  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [2:0]   dest_i = '0;
  logic [W-1:0] f_i = '0;
  logic [W-1:0] a_i = '0;
  logic         ram_lsb_in = 1'b0;
  logic         ram_msb_in = 1'b0;
  logic         q_lsb_in = 1'b0;
  logic         q_msb_in = 1'b0;
  logic         ram_lsb_out, ram_lsb_oe, ram_msb_out, ram_msb_oe;
  logic         q_lsb_out, q_lsb_oe, q_msb_out, q_msb_oe;
  logic [W-1:0] y_o, ram_wdata_o, q_o;
  logic         ram_we_o;

  int total = 0;
  int bad = 0;
  int mq = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  bsd_dest_ctl #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .dest_i(dest_i), .f_i(f_i), .a_i(a_i),
    .ram_lsb_in(ram_lsb_in), .ram_msb_in(ram_msb_in),
    .q_lsb_in(q_lsb_in), .q_msb_in(q_msb_in),
    .ram_lsb_out(ram_lsb_out), .ram_lsb_oe(ram_lsb_oe),
    .ram_msb_out(ram_msb_out), .ram_msb_oe(ram_msb_oe),
    .q_lsb_out(q_lsb_out), .q_lsb_oe(q_lsb_oe),
    .q_msb_out(q_msb_out), .q_msb_oe(q_msb_oe),
    .y_o(y_o), .ram_wdata_o(ram_wdata_o), .ram_we_o(ram_we_o), .q_o(q_o)
  );

  // Reference Q: plain integer arithmetic on a 4-bit value.
  always @(posedge clk) begin
    int c;
    c = int'(dest_i);
    if (!rst_n) mq = 0;
    else if (c == 0) mq = int'(f_i);
    else if (c == 4) mq = mq / 2 + int'(q_msb_in) * 8;
    else if (c == 6) mq = (mq * 2) % 16 + int'(q_lsb_in);
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_outputs();
    int c, f, a, ewd, e_r0, e_r3, e_q0, e_q3;
    string rt, qt;
    c = int'(dest_i);
    f = int'(f_i);
    a = int'(a_i);
    chk("R2 y", int'(y_o), (c == 2) ? a : f);
    chk("R3 we", int'(ram_we_o), (c >= 2) ? 1 : 0);
    if (c == 4 || c == 5)      begin ewd = f / 2 + int'(ram_msb_in) * 8; rt = "R4"; end
    else if (c == 6 || c == 7) begin ewd = (f * 2) % 16 + int'(ram_lsb_in); rt = "R5"; end
    else                       begin ewd = f; rt = (c < 4) ? "R7" : "R3"; end
    chk({rt, " wdata"}, int'(ram_wdata_o), ewd);
    e_r0 = (c == 4 || c == 5) ? 1 : 0;
    e_r3 = (c == 6 || c == 7) ? 1 : 0;
    chk({rt, " ram_lsb_oe"}, int'(ram_lsb_oe), e_r0);
    chk({rt, " ram_lsb_out"}, int'(ram_lsb_out), e_r0 ? f % 2 : 0);
    chk({rt, " ram_msb_oe"}, int'(ram_msb_oe), e_r3);
    chk({rt, " ram_msb_out"}, int'(ram_msb_out), e_r3 ? f / 8 : 0);
    e_q0 = (c == 4) ? 1 : 0;
    e_q3 = (c == 6) ? 1 : 0;
    if (c == 4)      qt = "R9";
    else if (c == 6) qt = "R10";
    else if (c < 4)  qt = "R7";
    else             qt = "R8";
    chk({qt, " q_lsb_oe"}, int'(q_lsb_oe), e_q0);
    chk({qt, " q_lsb_out"}, int'(q_lsb_out), e_q0 ? mq % 2 : 0);
    chk({qt, " q_msb_oe"}, int'(q_msb_oe), e_q3);
    chk({qt, " q_msb_out"}, int'(q_msb_out), e_q3 ? mq / 8 : 0);
    chk("R6 R8 R9 R10 q", int'(q_o), mq);
  endtask

  task automatic step(input int c, input int f, input int a,
                      input bit r0, input bit r3, input bit q0, input bit q3);
    @(negedge clk);
    dest_i = 3'(c);
    f_i = 4'(f);
    a_i = 4'(a);
    ram_lsb_in = r0;
    ram_msb_in = r3;
    q_lsb_in = q0;
    q_msb_in = q3;
    #1;
    check_outputs();
  endtask

  initial begin
    int seed;
    seed = 13;
    dest_i = 3'd0;
    f_i = 4'hF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset q", int'(q_o), 0);
    rst_n = 1'b1;

    // Directed: each code, pins opposing the bits that would otherwise shift in.
    for (int c = 0; c < 8; c++) begin
      step(0, 9, 6, 0, 0, 0, 0);
      step(c, 9, 6, 1, 1, 1, 1);
      step(c, 6, 9, 0, 0, 0, 0);
      step(c, 5, 10, 1, 0, 1, 0);
      step(c, 10, 5, 0, 1, 0, 1);
    end
    // Q-only vs RAM-only shift alternation.
    for (int k = 0; k < 6; k++) begin
      step(4, 12, 3, 1, 0, 0, 1);
      step(5, 3, 12, 0, 1, 1, 0);
      step(6, 12, 3, 0, 1, 1, 0);
      step(7, 3, 12, 1, 0, 0, 1);
    end
    // Pseudo-random run.
    for (int n = 0; n < 400; n++) begin
      seed = seed * 1103515245 + 12345;
      step((seed >>> 8) & 7, (seed >>> 12) & 15, (seed >>> 16) & 15,
           bit'((seed >>> 20) & 1), bit'((seed >>> 21) & 1),
           bit'((seed >>> 22) & 1), bit'((seed >>> 23) & 1));
    end
    // Reset in mid-run while the code asks for a load.
    step(0, 7, 0, 0, 0, 0, 0);
    @(negedge clk);
    rst_n = 1'b0;
    f_i = 4'd11;
    @(negedge clk);
    #1;
    chk("R1 mid-run reset q", int'(q_o), 0);
    rst_n = 1'b1;
    step(0, 11, 2, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule